// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer execution unit for the data-processing class of a classic 32-bit RISC core. Each operation is presented for one cycle with a 4-bit opcode, a set-flags bit, a first operand taken from a register, and a second operand that has already been through the barrel shifter, together with the shifter's carry-out. The block also receives the current NZCV condition flags and the index of the destination register. The register file, the shifter, condition-code evaluation and exception entry all sit outside the block.

One clock edge after an operation is issued, the block presents four outputs: the result, a write strobe for the destination register, the next NZCV value, and a request to restore the status register. The restore request replaces the normal flag update when flag setting targets the program counter. The flag rules depend on the opcode. Logical opcodes take their carry from the shifter and leave V alone. Arithmetic opcodes take carry and overflow from the adder. The four compare opcodes change only the flags and never the destination register.

Top module: `dp_alu`

## Requirements
- R1: Opcode values 0 to 15 select AND, EOR, SUB, RSB, ADD, ADC, SBC, RSC, TST, TEQ, CMP, CMN, ORR, MOV, BIC, MVN. The logical results are a&b (AND, TST), a^b (EOR, TEQ), a|b (ORR), b (MOV), a&~b (BIC) and ~b (MVN), where a is `op_a` and b is `op_b`.
- R2: SUB and CMP produce a-b, RSB produces b-a, and ADD and CMN produce a+b, all modulo 2^32.
- R3: ADC produces a+b+C. SBC produces a-b-(1-C). RSC produces b-a-(1-C). C is `flags_in[1]`.
- R4: For an issued operation, `rd_we` is 0 for opcodes 8 to 11 (TST, TEQ, CMP, CMN) and 1 for every other opcode.
- R5: When flags are updated, N (`flags_out[3]`) equals bit 31 of the result, and Z (`flags_out[2]`) is 1 exactly when the result is zero.
- R6: When a logical opcode sets flags, C (`flags_out[1]`) takes `shift_carry` and V (`flags_out[0]`) keeps the value of `flags_in[0]`.
- R7: For ADD, ADC and CMN with flags set, C is the unsigned carry out of bit 31, and V is bit 31 of ~(x^y)&(r^x), where x and y are the two addends and r is the result.
- R8: For SUB, SBC, RSB, RSC and CMP with flags set, C is 1 when no borrow occurs, and V is bit 31 of (x^y)&(r^x), where x is the minuend and y is the subtrahend.
- R9: When `set_flags` is 1 and `rd_idx` is 15, `status_restore` goes to 1 and `flags_out` equals `flags_in` unchanged. In every other case `status_restore` is 0.
- R10: When `set_flags` is 0, `flags_out` equals `flags_in` for every opcode.
- R11: All outputs are registered with one cycle of latency. While `rst_n` is low, every output is zero. In a cycle with `op_valid` low, the next cycle shows `rd_we` = 0, `status_restore` = 0 and `flags_out` = `flags_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| opcode | input | 4 | Operation select (see R1) |
| set_flags | input | 1 | Update the condition flags |
| op_a | input | 32 | First operand, from a register |
| op_b | input | 32 | Second operand, from the shifter |
| shift_carry | input | 1 | Carry-out of the shifter |
| flags_in | input | 4 | Current flags, N Z C V in bits 3 down to 0 |
| rd_idx | input | 4 | Destination register index |
| result | output | 32 | Operation result |
| rd_we | output | 1 | Destination register write strobe |
| flags_out | output | 4 | Next flags, N Z C V in bits 3 down to 0 |
| status_restore | output | 1 | Request to restore the status register |

## Verification
The bench concentrates on the carry edges. It drives 0xFFFFFFFF+1 and 0x7FFFFFFF+1, where an adder with the wrong carry or overflow formula reports C=0 or misses the signed wrap. It drives 0-1 and equal-operand subtraction, where a design that treats C as a borrow rather than as not-borrow would return the inverted C. It feeds ADC, SBC and RSC with both values of the incoming C: swapping the operands of a reverse subtract, or adding C where it should subtract NOT C, gives results that are off by one or negated. It also covers compare opcodes aimed at a live register, logical flag updates that must pass the shifter carry and keep V, and flag setting with destination 15, where a faulty design would overwrite NZCV instead of raising the restore request.

// File: rtl/dp_alu_pkg.sv
// Package: shared opcode type and classification helpers for the data-processing ALU.
// Assumes the opcode numbering is fixed by the instruction decoder.
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } dp_op_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    // Compare-only opcodes occupy 8..11
    function automatic logic op_is_compare(input dp_op_e op);
        return (op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN});
    endfunction

    // Opcodes whose carry comes from the shifter
    function automatic logic op_is_logical(input dp_op_e op);
        return (op inside {OP_AND, OP_EOR, OP_TST, OP_TEQ,
                           OP_ORR, OP_MOV, OP_BIC, OP_MVN});
    endfunction

endpackage

// File: rtl/dp_adder.sv
// Module: dp_adder
// One carry-propagate adder shared by all arithmetic opcodes. Subtraction is
// done as x + ~y + carry_in, so carry-out directly means "no borrow".
// Assumes the caller ignores the outputs for logical opcodes.
module dp_adder
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  dp_op_e           op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum,
    output logic             c_out,
    output logic             v_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] x, y;
    logic             ci;
    logic [WIDTH:0]   full;

    // Operand steering: pick addend order, inversion and carry-in per opcode
    always_comb begin
        x  = a;
        y  = b;
        ci = 1'b0;
        unique case (op)
            OP_SUB, OP_CMP: begin y = ~b; ci = 1'b1; end
            OP_SBC:         begin y = ~b; ci = c_in; end
            OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
            OP_RSC:         begin x = b; y = ~a; ci = c_in; end
            OP_ADC:         ci = c_in;
            default:        ci = 1'b0;
        endcase
    end

    // Single add with carry into the extra top bit
    always_comb begin
        full  = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
        sum   = full[MSB:0];
        c_out = full[WIDTH];
        v_out = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end

endmodule

// File: rtl/dp_logic.sv
// Module: dp_logic
// Bitwise unit for the logical and test opcodes.
// Assumes arithmetic opcodes take their result from dp_adder instead.
module dp_logic
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  dp_op_e           op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res
);
    // Bitwise function select
    always_comb begin
        unique case (op)
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_MOV:         res = b;
            OP_BIC:         res = a & ~b;
            OP_MVN:         res = ~b;
            default:        res = '0;
        endcase
    end

endmodule

// File: rtl/dp_flag_ctl.sv
// Module: dp_flag_ctl
// Derives the next NZCV value, the writeback decision and the status-restore
// request. Assumes flags_in holds the architectural flags for this operation.
module dp_flag_ctl
    import dp_alu_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15
) (
    input  dp_op_e           op,
    input  logic             set_flags,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [WIDTH-1:0] res,
    input  logic             add_c,
    input  logic             add_v,
    input  logic             shift_c,
    input  logic [3:0]       flags_in,
    output logic [3:0]       flags_next,
    output logic             writes_rd,
    output logic             restore_req
);
    logic dest_is_pc;

    assign dest_is_pc = (rd_idx == IDX_W'(PC_IDX));

    // Writeback and restore decisions
    always_comb begin
        writes_rd   = !op_is_compare(op);
        restore_req = set_flags && dest_is_pc;
    end

    // Flag update: hold unless setting flags to a non-PC destination
    always_comb begin
        flags_next = flags_in;
        if (set_flags && !dest_is_pc) begin
            flags_next[FLAG_N] = res[WIDTH-1];
            flags_next[FLAG_Z] = (res == '0);
            if (op_is_logical(op)) begin
                flags_next[FLAG_C] = shift_c;
            end else begin
                flags_next[FLAG_C] = add_c;
                flags_next[FLAG_V] = add_v;
            end
        end
    end

endmodule

// File: rtl/dp_alu.sv
// Module: dp_alu (top)
// Data-processing ALU: combinational adder and logic units feed one output
// register stage. Assumes op_b and shift_carry already come from the shifter
// and that the caller applies the condition code before raising op_valid.
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       opcode,
    input  logic             set_flags,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             shift_carry,
    input  logic [3:0]       flags_in,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] result,
    output logic             rd_we,
    output logic [3:0]       flags_out,
    output logic             status_restore
);
    dp_op_e           op;
    logic [WIDTH-1:0] add_sum, log_res, res_sel;
    logic             add_c, add_v;
    logic [3:0]       flags_next;
    logic             writes_rd, restore_req;

    assign op = dp_op_e'(opcode);

    dp_adder #(.WIDTH(WIDTH)) u_adder (
        .op    (op),
        .a     (op_a),
        .b     (op_b),
        .c_in  (flags_in[FLAG_C]),
        .sum   (add_sum),
        .c_out (add_c),
        .v_out (add_v)
    );

    dp_logic #(.WIDTH(WIDTH)) u_logic (
        .op  (op),
        .a   (op_a),
        .b   (op_b),
        .res (log_res)
    );

    // Result select between the bitwise unit and the adder
    assign res_sel = op_is_logical(op) ? log_res : add_sum;

    dp_flag_ctl #(.WIDTH(WIDTH), .IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_flags (
        .op          (op),
        .set_flags   (set_flags),
        .rd_idx      (rd_idx),
        .res         (res_sel),
        .add_c       (add_c),
        .add_v       (add_v),
        .shift_c     (shift_carry),
        .flags_in    (flags_in),
        .flags_next  (flags_next),
        .writes_rd   (writes_rd),
        .restore_req (restore_req)
    );

    // Output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result         <= '0;
            rd_we          <= 1'b0;
            flags_out      <= '0;
            status_restore <= 1'b0;
        end else begin
            result         <= res_sel;
            rd_we          <= op_valid && writes_rd;
            status_restore <= op_valid && restore_req;
            flags_out      <= op_valid ? flags_next : flags_in;
        end
    end

    // R4: compare opcodes never strobe the destination
    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[3:2] == 2'b10) |=> !rd_we);

    // R9: restore request leaves the flags as they came in
    a_r9_restore_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && set_flags && rd_idx == IDX_W'(PC_IDX))
        |=> (status_restore && flags_out == $past(flags_in)));

    // R10: flags pass through when set_flags is clear
    a_r10_no_s_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !set_flags) |=> (flags_out == $past(flags_in) && !status_restore));

    // R5: N and Z track the registered result on an update
    a_r5_nz_track: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && set_flags && rd_idx != IDX_W'(PC_IDX))
        |=> (flags_out[FLAG_N] == result[WIDTH-1] && flags_out[FLAG_Z] == (result == '0)));

    // R6: logical updates keep V and take the shifter carry
    a_r6_logic_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && set_flags && rd_idx != IDX_W'(PC_IDX) && op_is_logical(op))
        |=> (flags_out[FLAG_V] == $past(flags_in[FLAG_V]) &&
             flags_out[FLAG_C] == $past(shift_carry)));

    // R11: an idle cycle produces no write and no restore
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!rd_we && !status_restore));

endmodule

// File: tb/test_dp_alu.sv
`timescale 1ns/1ps
module test_dp_alu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  opcode;
    logic        set_flags;
    logic [31:0] op_a, op_b;
    logic        shift_carry;
    logic [3:0]  flags_in;
    logic [3:0]  rd_idx;
    logic [31:0] result;
    logic        rd_we;
    logic [3:0]  flags_out;
    logic        status_restore;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dp_alu i_dp_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .set_flags(set_flags), .op_a(op_a), .op_b(op_b),
        .shift_carry(shift_carry), .flags_in(flags_in), .rd_idx(rd_idx),
        .result(result), .rd_we(rd_we), .flags_out(flags_out),
        .status_restore(status_restore)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference: {res[31:0], we, nzcv[3:0], restore}
    function automatic logic [37:0] model(input logic [3:0] op, input logic s,
        input logic [31:0] a, input logic [31:0] b, input logic sc,
        input logic [3:0] f, input logic [3:0] rd);
        logic [31:0] r;
        logic [63:0] wide;
        logic [31:0] x, y;
        logic        c, v, logical, arith_add, bin;
        logic [3:0]  nf;
        c = f[1]; v = f[0];
        logical = 1'b0; arith_add = 1'b0;
        x = a; y = b; bin = 1'b0;
        case (op)
            4'd0, 4'd8:  begin r = a & b;  logical = 1; end
            4'd1, 4'd9:  begin r = a ^ b;  logical = 1; end
            4'd12:       begin r = a | b;  logical = 1; end
            4'd13:       begin r = b;      logical = 1; end
            4'd14:       begin r = a & ~b; logical = 1; end
            4'd15:       begin r = ~b;     logical = 1; end
            4'd4, 4'd11, 4'd5: begin
                arith_add = 1;
                wide = 64'(a) + 64'(b) + ((op == 4'd5) ? 64'(f[1]) : 64'd0);
                r = wide[31:0]; c = wide[32];
                v = (~(a ^ b) & (r ^ a)) >> 31;
            end
            default: begin
                if (op == 4'd3 || op == 4'd7) begin x = b; y = a; end
                bin = (op == 4'd6 || op == 4'd7) ? !f[1] : 1'b0;
                r = x - y - 32'(bin);
                c = (64'(x) >= 64'(y) + 64'(bin));
                v = ((x ^ y) & (r ^ x)) >> 31;
            end
        endcase
        nf = f;
        if (s && rd != 4'd15) begin
            nf[3] = r[31];
            nf[2] = (r == 32'd0);
            if (logical) nf[1] = sc;
            else begin nf[1] = c; nf[0] = v; end
        end
        if (arith_add) begin end
        return {r, !(op >= 4'd8 && op <= 4'd11), nf, s && rd == 4'd15};
    endfunction

    task automatic run_op(input string req, input logic [3:0] op, input logic s,
        input logic [31:0] a, input logic [31:0] b, input logic sc,
        input logic [3:0] f, input logic [3:0] rd);
        logic [37:0] e;
        op_valid = 1; opcode = op; set_flags = s; op_a = a; op_b = b;
        shift_carry = sc; flags_in = f; rd_idx = rd;
        e = model(op, s, a, b, sc, f, rd);
        @(posedge clk); #1;
        chk(req, "result", result, e[37:6]);
        chk(req, "rd_we", 32'(rd_we), 32'(e[5]));
        chk(req, "flags", 32'(flags_out), 32'(e[4:1]));
        chk(req, "restore", 32'(status_restore), 32'(e[0]));
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; op_valid = 1; opcode = 4'd4; set_flags = 1;
        op_a = 32'h5; op_b = 32'h7; shift_carry = 1; flags_in = 4'hF; rd_idx = 4'd1;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11", "reset result", result, 0);
        chk("R11", "reset we", 32'(rd_we), 0);
        chk("R11", "reset flags", 32'(flags_out), 0);
        chk("R11", "reset restore", 32'(status_restore), 0);
        rst_n = 1;

        // R11 idle cycle
        op_valid = 0; opcode = 4'd4; set_flags = 1; flags_in = 4'hA; rd_idx = 4'd15;
        @(posedge clk); #1;
        chk("R11", "idle we", 32'(rd_we), 0);
        chk("R11", "idle restore", 32'(status_restore), 0);
        chk("R11", "idle flags", 32'(flags_out), 32'hA);

        // R1 logical ops
        run_op("R1", 4'd0,  1, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 4'h1, 4'd2);
        run_op("R1", 4'd1,  0, 32'hAAAA_5555, 32'hFFFF_0000, 1, 4'h3, 4'd2);
        run_op("R1", 4'd12, 1, 32'h0000_0000, 32'h0000_0000, 1, 4'h1, 4'd0);
        run_op("R1", 4'd14, 1, 32'hFFFF_FFFF, 32'h8000_0001, 0, 4'h0, 4'd7);
        run_op("R1", 4'd15, 1, 32'h1234_5678, 32'h0000_0000, 1, 4'h0, 4'd7);
        run_op("R1", 4'd13, 0, 32'h1111_1111, 32'hDEAD_BEEF, 0, 4'h5, 4'd3);
        // R6 shifter carry, V held
        run_op("R6", 4'd12, 1, 32'h1, 32'h2, 1, 4'h1, 4'd4);
        run_op("R6", 4'd0,  1, 32'h1, 32'h2, 0, 4'hE, 4'd4);
        // R2 / R7 addition edges
        run_op("R7", 4'd4, 1, 32'hFFFF_FFFF, 32'h1, 0, 4'h0, 4'd1);
        run_op("R7", 4'd4, 1, 32'h7FFF_FFFF, 32'h1, 0, 4'h0, 4'd1);
        run_op("R7", 4'd4, 1, 32'h8000_0000, 32'h8000_0000, 0, 4'h0, 4'd1);
        run_op("R2", 4'd4, 0, 32'd100, 32'd23, 0, 4'h0, 4'd1);
        // R8 subtraction edges
        run_op("R8", 4'd2, 1, 32'd0, 32'd1, 0, 4'h0, 4'd1);
        run_op("R8", 4'd2, 1, 32'd9, 32'd9, 0, 4'h0, 4'd1);
        run_op("R8", 4'd2, 1, 32'h8000_0000, 32'd1, 0, 4'h0, 4'd1);
        run_op("R2", 4'd3, 1, 32'd5, 32'd3, 0, 4'h0, 4'd1);
        // R3 carry-in ops with both carry values
        run_op("R3", 4'd5, 1, 32'hFFFF_FFFF, 32'h0, 0, 4'h2, 4'd1);
        run_op("R3", 4'd5, 1, 32'h10, 32'h20, 0, 4'h0, 4'd1);
        run_op("R3", 4'd6, 1, 32'd10, 32'd3, 0, 4'h0, 4'd1);
        run_op("R3", 4'd6, 1, 32'd10, 32'd3, 0, 4'h2, 4'd1);
        run_op("R3", 4'd7, 1, 32'd3, 32'd10, 0, 4'h0, 4'd1);
        run_op("R3", 4'd7, 1, 32'd3, 32'd10, 0, 4'h2, 4'd1);
        // R4 compares with a live destination
        run_op("R4", 4'd10, 1, 32'd4, 32'd4, 0, 4'h0, 4'd3);
        run_op("R4", 4'd11, 1, 32'hFFFF_FFFF, 32'd1, 0, 4'h0, 4'd3);
        run_op("R4", 4'd8,  1, 32'hF0, 32'h0F, 1, 4'h1, 4'd3);
        run_op("R4", 4'd9,  0, 32'hF0, 32'hF0, 1, 4'h1, 4'd3);
        // R9 destination 15 with flags set
        run_op("R9", 4'd2, 1, 32'd0, 32'd1, 0, 4'h6, 4'd15);
        run_op("R9", 4'd13, 1, 32'd0, 32'd0, 1, 4'h9, 4'd15);
        // R10 flags held with S clear
        run_op("R10", 4'd2, 0, 32'd0, 32'd1, 0, 4'h9, 4'd15);
        run_op("R10", 4'd10, 0, 32'd0, 32'd0, 1, 4'h5, 4'd2);

        // Random mix (R1..R10), fixed seed
        begin
            int unsigned seed = 32'd2024;
            void'($urandom(seed));
        end
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] rop, rfl, rrd;
            logic [31:0] ra, rb;
            rop = 4'($urandom); rfl = 4'($urandom); rrd = 4'($urandom);
            ra = $urandom; rb = $urandom;
            if (($urandom % 8) == 0) rb = ra;
            if (($urandom % 8) == 0) ra = 32'hFFFF_FFFF;
            run_op("R5", rop, 1'($urandom), ra, rb, 1'($urandom), rfl, rrd);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule